// File: doc/BRIEF.md
# Debug Port Instruction Gate

This block sits between the instruction register of a boundary-scan test port and the device's instruction decoder, and it decides which instruction codes reach the decoder. After a power-on reset the gate is locked: only the small set of instructions that the boundary-scan standard requires can pass. Every other code reaches the decoder as the all-ones bypass instruction.

A host that wants the full instruction set raises an unlock request. The gate does not open at once. It first asks a memory-clear controller to wipe all configuration storage, including the volatile key, and it waits for that controller to report completion. Only then does it move to full access. As a result, the debug port can never reach design contents or key material.

A two-bit mode output reports the gate's state to the rest of the chip. A power-on reset always locks the gate again.

Top module: `dbg_instr_gate`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `gate_mode` is 2'b00 (locked), `erase_req` is 0, `dec_valid` is 0 and `dec_code` is all ones.
- R2: In locked mode, a valid code that is one of the permitted instructions reaches `dec_code` unchanged one cycle later. The permitted instructions are all ones (bypass), 8'h00, 8'h01 and 8'h02.
- R3: In locked mode, a high `unlock_req` makes `gate_mode` 2'b01 (wiping) and `erase_req` 1 on the next cycle.
- R4: `gate_mode` becomes 2'b10 (open) only on the cycle after `erase_done` is sampled high in wiping mode. On that same cycle `erase_req` returns to 0.
- R5: In locked and wiping modes, a valid code that is not permitted appears on `dec_code` as all ones one cycle later. This includes the cycle in which `erase_done` arrives.
- R6: A high `unlock_req` in wiping or open mode has no effect on `gate_mode` or `erase_req`.
- R7: A reset returns the gate to locked mode from wiping or open mode.
- R8: In open mode, every valid code reaches `dec_code` unchanged one cycle later.
- R9: A high `erase_done` outside wiping mode has no effect on `gate_mode`.
- R10: `dec_valid` follows `ir_valid` with one cycle of latency. When `ir_valid` is low, `dec_code` becomes all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ir_valid | input | 1 | `ir_code` holds a captured instruction |
| ir_code | input | IR_W | Captured instruction code |
| unlock_req | input | 1 | Host request for full instruction access |
| erase_done | input | 1 | Memory-clear controller reports wipe complete |
| erase_req | output | 1 | Request to the memory-clear controller, held through the wipe |
| dec_valid | output | 1 | `dec_code` is valid for the decoder |
| dec_code | output | IR_W | Instruction forwarded to the decoder |
| gate_mode | output | 2 | 00 locked, 01 wiping, 10 open |

## Verification
The bench targets the boundary between wiping and open mode. It sends a non-permitted code in the same cycle as `erase_done`. A gate that opened one cycle early would pass that code through instead of replacing it with bypass. It also repeats unlock requests during the wipe and after opening, and pulses `erase_done` while locked. A design that restarted the wipe or opened without a wipe would show the wrong mode. Finally, it resets the gate in the middle of a wipe and again after it has opened, then checks that a non-permitted code is blocked once more.

// File: rtl/dig_pkg.sv
package dig_pkg;
  typedef enum logic [1:0] {
    GM_LOCKED = 2'b00,
    GM_WIPING = 2'b01,
    GM_OPEN   = 2'b10
  } gate_mode_e;
endpackage

// File: rtl/dig_mode_fsm.sv
module dig_mode_fsm
  import dig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       unlock_req,
  input  logic       erase_done,
  output gate_mode_e mode_q,
  output logic       erase_req
);
  gate_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      GM_LOCKED: if (unlock_req) mode_d = GM_WIPING;
      GM_WIPING: if (erase_done) mode_d = GM_OPEN;
      GM_OPEN:   mode_d = GM_OPEN;
      default:   mode_d = GM_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= GM_LOCKED;
    else     mode_q <= mode_d;
  end

  assign erase_req = (mode_q == GM_WIPING);

  assert_wipe_starts_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == GM_LOCKED && unlock_req) |=> (mode_q == GM_WIPING && erase_req));
  assert_open_after_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == GM_OPEN) |-> $past(mode_q == GM_WIPING && erase_done));
  assert_unlock_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == GM_WIPING && !erase_done) |=> (mode_q == GM_WIPING));
  assert_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == GM_LOCKED && !unlock_req) |=> (mode_q == GM_LOCKED));
  assert_reset_locks_R7: assert property (@(posedge clk)
    $past(rst) |-> (mode_q == GM_LOCKED && !erase_req));
endmodule

// File: rtl/dig_ir_filter.sv
module dig_ir_filter #(
  parameter int                      IR_W      = 8,
  parameter int                      N_PUB     = 3,
  parameter logic [N_PUB*IR_W-1:0]   PUB_CODES = 24'h020100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            full_access,
  input  logic            ir_valid,
  input  logic [IR_W-1:0] ir_code,
  output logic            dec_valid,
  output logic [IR_W-1:0] dec_code
);
  localparam logic [IR_W-1:0] BYP = '1;

  logic [N_PUB-1:0] hit_vec;
  logic             hit;

  for (genvar g = 0; g < N_PUB; g++) begin : g_pub
    assign hit_vec[g] = (ir_code == PUB_CODES[g*IR_W +: IR_W]);
  end

  assign hit = (|hit_vec) || (ir_code == BYP);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_code  <= BYP;
    end else begin
      dec_valid <= ir_valid;
      dec_code  <= (ir_valid && (full_access || hit)) ? ir_code : BYP;
    end
  end

  assert_blocked_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (ir_valid && !full_access && !hit) |=> (dec_valid && dec_code == BYP));
  assert_open_passes_R8: assert property (@(posedge clk) disable iff (rst)
    (ir_valid && full_access) |=> (dec_valid && dec_code == $past(ir_code)));
  assert_idle_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    !ir_valid |=> (!dec_valid && dec_code == BYP));
endmodule

// File: rtl/dbg_instr_gate.sv
module dbg_instr_gate
  import dig_pkg::*;
#(
  parameter int                    IR_W      = 8,
  parameter int                    N_PUB     = 3,
  parameter logic [N_PUB*IR_W-1:0] PUB_CODES = 24'h020100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ir_valid,
  input  logic [IR_W-1:0] ir_code,
  input  logic            unlock_req,
  input  logic            erase_done,
  output logic            erase_req,
  output logic            dec_valid,
  output logic [IR_W-1:0] dec_code,
  output logic [1:0]      gate_mode
);
  gate_mode_e mode_q;

  dig_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .unlock_req (unlock_req),
    .erase_done (erase_done),
    .mode_q     (mode_q),
    .erase_req  (erase_req)
  );

  dig_ir_filter #(
    .IR_W      (IR_W),
    .N_PUB     (N_PUB),
    .PUB_CODES (PUB_CODES)
  ) u_filter (
    .clk         (clk),
    .rst         (rst),
    .full_access (mode_q == GM_OPEN),
    .ir_valid    (ir_valid),
    .ir_code     (ir_code),
    .dec_valid   (dec_valid),
    .dec_code    (dec_code)
  );

  assign gate_mode = mode_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!dec_valid && dec_code == '1 && gate_mode == 2'b00));
endmodule

// File: tb/sim_dbg_instr_gate.sv
`timescale 1ns/1ps
module sim_dbg_instr_gate;
  localparam int IR_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ir_valid = 1'b0;
  logic [IR_W-1:0] ir_code = '0;
  logic            unlock_req = 1'b0;
  logic            erase_done = 1'b0;
  logic            erase_req;
  logic            dec_valid;
  logic [IR_W-1:0] dec_code;
  logic [1:0]      gate_mode;

  always #2.5 clk = ~clk;

  dbg_instr_gate u0 (
    .clk(clk), .rst(rst), .ir_valid(ir_valid), .ir_code(ir_code),
    .unlock_req(unlock_req), .erase_done(erase_done), .erase_req(erase_req),
    .dec_valid(dec_valid), .dec_code(dec_code), .gate_mode(gate_mode)
  );

  typedef struct {
    logic [1:0]      m;
    logic            er;
    logic            v;
    logic [IR_W-1:0] c;
    string           tag;
  } exp_t;

  exp_t       sb[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [1:0] mode_m = 2'b00;
  bit         finished = 0;

  function automatic bit permitted(input logic [IR_W-1:0] c);
    return (c == 8'hFF) || (c == 8'h00) || (c == 8'h01) || (c == 8'h02);
  endfunction

  task automatic step(input bit r, input bit v, input logic [IR_W-1:0] c,
                      input bit ul, input bit dn, input string tag);
    exp_t       e;
    logic [1:0] nxt;
    @(negedge clk);
    rst = r; ir_valid = v; ir_code = c; unlock_req = ul; erase_done = dn;
    if (r) begin
      nxt = 2'b00; e.v = 1'b0; e.c = '1;
    end else begin
      nxt = mode_m;
      if (mode_m == 2'b00 && ul) nxt = 2'b01;
      else if (mode_m == 2'b01 && dn) nxt = 2'b10;
      e.v = v;
      e.c = (v && (mode_m == 2'b10 || permitted(c))) ? c : '1;
    end
    e.m = nxt; e.er = (nxt == 2'b01); e.tag = tag;
    mode_m = nxt;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (gate_mode !== e.m || erase_req !== e.er || dec_valid !== e.v || dec_code !== e.c) begin
        n_bad++;
        $display("FAIL %s: got mode=%b req=%b v=%b code=%h, expected mode=%b req=%b v=%b code=%h",
                 e.tag, gate_mode, erase_req, dec_valid, dec_code, e.m, e.er, e.v, e.c);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(1, 1, 8'h55, 1, 1, "R1 reset");
    step(1, 0, 8'h00, 0, 0, "R1 reset");
    step(0, 1, 8'h00, 0, 0, "R2 public 00");
    step(0, 1, 8'h01, 0, 0, "R2 public 01");
    step(0, 1, 8'h02, 0, 0, "R2 public 02");
    step(0, 1, 8'hFF, 0, 0, "R2 bypass");
    step(0, 1, 8'h03, 0, 0, "R5 blocked 03");
    step(0, 1, 8'h55, 0, 0, "R5 blocked 55");
    step(0, 1, 8'hFE, 0, 0, "R5 blocked FE");
    step(0, 0, 8'h01, 0, 0, "R10 idle");
    step(0, 1, 8'h55, 0, 1, "R9 done while locked");
    step(0, 1, 8'h55, 0, 0, "R9 still locked");
    step(0, 1, 8'h55, 1, 0, "R3 unlock");
    step(0, 1, 8'h55, 0, 0, "R5 blocked while wiping");
    step(0, 1, 8'h01, 1, 0, "R6 unlock during wipe");
    step(0, 1, 8'h77, 0, 0, "R5 wiping");
    step(0, 1, 8'h55, 0, 1, "R4 done cycle still filtered");
    step(0, 1, 8'h55, 0, 0, "R8 open passes 55");
    step(0, 1, 8'h03, 1, 0, "R6 unlock while open");
    step(0, 1, 8'hFE, 0, 1, "R9 done while open");
    step(0, 0, 8'h12, 0, 0, "R10 idle open");
    step(1, 1, 8'h55, 0, 0, "R7 reset from open");
    step(0, 1, 8'h55, 0, 0, "R7 locked again");
    step(0, 1, 8'h03, 1, 0, "R3 unlock again");
    step(0, 1, 8'h03, 0, 0, "R5 wiping");
    step(1, 1, 8'h03, 0, 1, "R7 reset mid wipe");
    step(0, 1, 8'h03, 0, 1, "R7 done ignored after reset");
    step(0, 1, 8'h02, 0, 0, "R2 public after reset");
    step(0, 0, 8'h00, 0, 0, "R10 idle end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule